// File: doc/BRIEF.md
# Burst-Mode Sequencing Controller

This block is a clocked model of a six-state burst-mode controller with three inputs (A, B, C) and two outputs (Y, Z). In every state it waits for one of the input bursts allowed there: a set of signal edges that may arrive one at a time, in any order and with any spacing, or together. Once the last edge of a burst has been seen, the controller drives that burst's output values and moves to the next state in the same clock step. An output burst may change no output at all.

The inputs pass through multi-flop synchronizers. Each state stores the input vector it is always entered with. A burst is complete when the synchronized inputs equal that vector with every bit of the burst inverted. An edge that fits no burst allowed in the current state is not decoded. The same holds for a signal that returns to its entry value before its burst completes. Either case sets a sticky error flag and freezes the controller until reset. Busy and stable status outputs let the environment respect the hold rule: it starts the next burst only after the controller has settled from the previous one.

Top module: `burst_ctrl`

## Requirements
- R1: After reset the controller is in state 0 (cur_state=3'd0), drives out_y=0 and out_z=1, and shows busy=0, stable=1 and err=0.
- R2: With the inputs in ABC order: from state 0 the burst A rise + C rise sets out_z=0 and enters state 1. From state 1, C fall sets out_z=1 and enters state 2. From state 2, C rise sets out_y=1 and enters state 4.
- R3: From state 0 the burst A rise + B rise gives YZ=10 and enters state 3. From state 3, B fall + C rise gives YZ=11 and enters state 4. From state 4, A fall gives YZ=01 and enters state 5. From state 5, C fall leaves YZ=01 and enters state 0.
- R4: The edges of a burst may arrive in any order, and each order gives the same next state and outputs.
- R5: While a burst is only partly received, the state and the outputs stay unchanged.
- R6: The state and outputs update on the third rising clock edge after the last edge of a burst is applied: two synchronizer stages, then one register.
- R7: Without an error, busy is high and stable is low from the moment the first synchronized edge of a burst is seen until the state update. At all other times busy is low and stable is high.
- R8: An edge that belongs to no burst allowed in the current state (for example B rising in state 1) sets err=1 and holds the state and outputs. While err is set, busy and stable are both low.
- R9: A signal that rises and then falls back before its burst completes (for example A in state 0) sets err=1.
- R10: Once set, err stays set and the state stays frozen whatever the inputs do, until reset clears it.
- R11: All edges of a burst arriving in the same clock cycle complete the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Input A (asynchronous) |
| in_b | input | 1 | Input B (asynchronous) |
| in_c | input | 1 | Input C (asynchronous) |
| out_y | output | 1 | Output Y |
| out_z | output | 1 | Output Z |
| cur_state | output | 3 | Current state number, binary 0 to 5 |
| busy | output | 1 | A burst is partly or fully received but not yet acted on |
| stable | output | 1 | Settled in a state with no pending edge |
| err | output | 1 | Sticky error: illegal or reverted edge |

## Verification
The bench goes after partial bursts, where a controller that fires early would change Y/Z after only one of the two edges. It reverses the edge order, which catches a decoder that tracks edges in a fixed sequence, and it applies both edges in the same cycle. It checks the exact update cycle, so an extra or missing synchronizer stage shows up as a one-cycle shift. It also drives an edge foreign to the state and a reverting edge, where a lax design would stay silent, keep moving after the error, or fail to clear it on reset.

// File: rtl/bmc_pkg.sv
// Package: shared sizes, state type and per-state entry values of the
// burst-mode controller. Inputs are packed {A,B,C}; outputs {Y,Z}.
package bmc_pkg;
    localparam int NUM_IN  = 3;
    localparam int NUM_OUT = 2;
    localparam int NUM_ST  = 6;
    localparam int ST_W    = $clog2(NUM_ST);

    typedef logic [ST_W-1:0]    st_t;
    typedef logic [NUM_IN-1:0]  in_t;
    typedef logic [NUM_OUT-1:0] out_t;

    // One permitted input burst leaving a state.
    typedef struct packed {
        logic en;
        in_t  mask;
        st_t  nxt;
    } arc_t;

    // Input vector every arc into a state delivers (unique entry point).
    function automatic in_t entry_in(st_t s);
        case (s)
            3'd0:    return 3'b000;
            3'd1:    return 3'b101;
            3'd2:    return 3'b100;
            3'd3:    return 3'b110;
            3'd4:    return 3'b101;
            3'd5:    return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    // Output vector held while in a state (set by the arc into it).
    function automatic out_t entry_out(st_t s);
        case (s)
            3'd0:    return 2'b01;
            3'd1:    return 2'b00;
            3'd2:    return 2'b01;
            3'd3:    return 2'b10;
            3'd4:    return 2'b11;
            3'd5:    return 2'b01;
            default: return 2'b01;
        endcase
    endfunction
endpackage

// File: rtl/bmc_sync.sv
// Module: bmc_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independently synchronizable (bursts tolerate skew).
module bmc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop stage of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= d;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bmc_arcs.sv
// Module: bmc_arcs
// Burst table: for the current state, the two possible outgoing bursts
// (mask of inputs that must toggle, next state). Assumes the maximal-set
// rule holds, so no mask of a state is a subset of another.
module bmc_arcs
    import bmc_pkg::*;
(
    input  st_t  state,
    output arc_t arc0,
    output arc_t arc1
);
    // Purpose: decode permitted bursts of the current state
    always_comb begin
        arc0 = '{en: 1'b1, mask: 3'b000, nxt: 3'd0};
        arc1 = '{en: 1'b0, mask: 3'b000, nxt: 3'd0};
        case (state)
            3'd0: begin
                arc0 = '{en: 1'b1, mask: 3'b101, nxt: 3'd1};
                arc1 = '{en: 1'b1, mask: 3'b110, nxt: 3'd3};
            end
            3'd1:    arc0 = '{en: 1'b1, mask: 3'b001, nxt: 3'd2};
            3'd2:    arc0 = '{en: 1'b1, mask: 3'b001, nxt: 3'd4};
            3'd3:    arc0 = '{en: 1'b1, mask: 3'b011, nxt: 3'd4};
            3'd4:    arc0 = '{en: 1'b1, mask: 3'b100, nxt: 3'd5};
            3'd5:    arc0 = '{en: 1'b1, mask: 3'b001, nxt: 3'd0};
            default: arc0 = '{en: 1'b0, mask: 3'b000, nxt: 3'd0};
        endcase
    end
endmodule

// File: rtl/bmc_engine.sv
// Module: bmc_engine
// Compares synchronized inputs with the state's entry vector, detects burst
// completion, illegal or reverted edges, and updates state and outputs.
// Assumes the environment obeys the hold rule between bursts.
module bmc_engine
    import bmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  in_t  sin,
    input  arc_t arc0,
    input  arc_t arc1,
    output st_t  state,
    output out_t outs,
    output logic busy,
    output logic stable,
    output logic err
);
    in_t  diff;
    in_t  seen;
    logic hit0, hit1, fits0, fits1, bad_edge, reverted;

    // Purpose: classify the current input pattern against the bursts
    always_comb begin
        diff     = sin ^ entry_in(state);
        hit0     = arc0.en && (diff == arc0.mask);
        hit1     = arc1.en && (diff == arc1.mask);
        fits0    = arc0.en && ((diff & ~arc0.mask) == '0);
        fits1    = arc1.en && ((diff & ~arc1.mask) == '0);
        bad_edge = !fits0 && !fits1;
        reverted = (seen & ~diff) != '0;
    end

    // Purpose: state, output, edge history and sticky error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
            outs  <= entry_out('0);
            seen  <= '0;
            err   <= 1'b0;
        end else if (!err) begin
            if (hit0) begin
                state <= arc0.nxt;
                outs  <= entry_out(arc0.nxt);
                seen  <= '0;
            end else if (hit1) begin
                state <= arc1.nxt;
                outs  <= entry_out(arc1.nxt);
                seen  <= '0;
            end else if (bad_edge || reverted) begin
                err <= 1'b1;
            end else begin
                seen <= diff;
            end
        end
    end

    assign busy   = !err && (diff != '0);
    assign stable = !err && (diff == '0);
endmodule

// File: rtl/burst_ctrl.sv
// Module: burst_ctrl (top)
// Six-state burst-mode controller: synchronizes A/B/C, waits for a full
// input burst in any order, then drives Y/Z and moves state in one step.
// Assumes inputs are 000 while reset is applied.
module burst_ctrl
    import bmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       in_c,
    output logic       out_y,
    output logic       out_z,
    output logic [2:0] cur_state,
    output logic       busy,
    output logic       stable,
    output logic       err
);
    in_t  sin;
    arc_t arc0, arc1;
    st_t  state;
    out_t outs;

    bmc_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(entry_in('0))) u_sync (
        .clk(clk), .rst_n(rst_n), .d({in_a, in_b, in_c}), .q(sin)
    );

    bmc_arcs u_arcs (.state(state), .arc0(arc0), .arc1(arc1));

    bmc_engine u_eng (
        .clk(clk), .rst_n(rst_n), .sin(sin), .arc0(arc0), .arc1(arc1),
        .state(state), .outs(outs), .busy(busy), .stable(stable), .err(err)
    );

    assign out_y     = outs[1];
    assign out_z     = outs[0];
    assign cur_state = state;
endmodule

// File: rtl/burst_ctrl_chk.sv
// Module: burst_ctrl_chk
// Assertion checker for burst_ctrl, attached by bind.
module burst_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_y,
    input logic       out_z,
    input logic [2:0] cur_state,
    input logic       busy,
    input logic       stable,
    input logic       err
);
    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state < 3'd6);
    // R3
    state4_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == 3'd4) |-> ({out_y, out_z} == 2'b11));
    // R5
    out_moves_with_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({out_y, out_z}) |-> !$stable(cur_state));
    // R7
    busy_stable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && stable));
    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !stable));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(cur_state)));
endmodule

bind burst_ctrl burst_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .out_y(out_y), .out_z(out_z),
    .cur_state(cur_state), .busy(busy), .stable(stable), .err(err)
);

// File: tb/burst_ctrl_tb.sv
module burst_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
    logic out_y, out_z, busy, stable, err;
    logic [2:0] cur_state;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_y(out_y), .out_z(out_z), .cur_state(cur_state),
        .busy(busy), .stable(stable), .err(err)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(logic a, logic b, logic c);
        @(negedge clk);
        in_a = a; in_b = b; in_c = c;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic chk_pos(string tag, int st, logic [1:0] yz);
        chk({tag, " state"}, cur_state, st);
        chk({tag, " YZ"}, {out_y, out_z}, yz);
        chk({tag, " stable"}, stable, 1);
        chk({tag, " busy"}, busy, 0);
    endtask

    task automatic do_reset();
        drive(0, 0, 0);
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk_pos("R1 reset", 0, 2'b01);
        chk("R1 err", err, 0);
    endtask

    // State 0 -> 1 -> 2 -> 4 -> 5 -> 0, with C before A (R4) and latency (R6)
    task automatic t_path_a();
        drive(0, 0, 1);
        settle();
        chk("R5 partial state", cur_state, 0);
        chk("R5 partial YZ", {out_y, out_z}, 2'b01);
        chk("R7 busy partial", busy, 1);
        chk("R7 stable partial", stable, 0);
        drive(1, 0, 1);
        repeat (2) @(posedge clk);
        #1;
        chk("R6 before update", cur_state, 0);
        @(posedge clk);
        #1;
        chk("R6 at update", cur_state, 1);
        chk("R4 C-then-A YZ", {out_y, out_z}, 2'b00);
        chk("R7 busy after update", busy, 0);
        drive(1, 0, 0); settle(); chk_pos("R2 s1->s2", 2, 2'b01);
        drive(1, 0, 1); settle(); chk_pos("R2 s2->s4", 4, 2'b11);
        drive(0, 0, 1); settle(); chk_pos("R3 s4->s5", 5, 2'b01);
        drive(0, 0, 0); settle(); chk_pos("R3 s5->s0", 0, 2'b01);
    endtask

    // A and B together (R11), then B fall / C rise in two steps
    task automatic t_path_b();
        drive(1, 1, 0); settle(); chk_pos("R11 R3 s0->s3", 3, 2'b10);
        drive(1, 0, 0); settle();
        chk("R5 s3 partial state", cur_state, 3);
        chk("R7 s3 busy", busy, 1);
        drive(1, 0, 1); settle(); chk_pos("R3 s3->s4", 4, 2'b11);
        drive(0, 0, 1); settle(); chk_pos("R3 s4->s5 b", 5, 2'b01);
        drive(0, 0, 0); settle(); chk_pos("R3 s5->s0 b", 0, 2'b01);
    endtask

    // A before C gives the same result
    task automatic t_order();
        drive(1, 0, 0); settle();
        chk("R5 A only state", cur_state, 0);
        drive(1, 0, 1); settle(); chk_pos("R4 A-then-C", 1, 2'b00);
        drive(1, 0, 0); settle();
        drive(1, 0, 1); settle();
        drive(0, 0, 1); settle();
        drive(0, 0, 0); settle(); chk_pos("R4 back home", 0, 2'b01);
    endtask

    // Foreign edge in state 1, then frozen until reset
    task automatic t_illegal();
        drive(1, 0, 1); settle(); chk("R8 reach s1", cur_state, 1);
        drive(1, 1, 1); settle();
        chk("R8 err", err, 1);
        chk("R8 state held", cur_state, 1);
        chk("R8 YZ held", {out_y, out_z}, 2'b00);
        chk("R8 busy low", busy, 0);
        chk("R8 stable low", stable, 0);
        drive(1, 0, 0); settle();
        chk("R10 still err", err, 1);
        chk("R10 frozen", cur_state, 1);
        do_reset();
        chk("R10 reset clears err", err, 0);
        chk_pos("R10 reset", 0, 2'b01);
    endtask

    // A rises then falls back in state 0
    task automatic t_revert();
        drive(1, 0, 0); settle();
        chk("R9 no err yet", err, 0);
        drive(0, 0, 0); settle();
        chk("R9 err", err, 1);
        chk("R9 state", cur_state, 0);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_path_a();
        t_path_b();
        t_order();
        t_illegal();
        t_revert();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule